// File: doc/BRIEF.md
# Transition-to-Level Handshake Bridge

This block joins a sender that signals by transitions to a receiver that expects a level handshake with return to zero. On the sender side, every change of the request wire, rising or falling, announces one transfer, and the bridge answers by changing its acknowledge wire once. On the receiver side, the bridge runs a full level cycle for each announced transfer. It raises its request, waits for the acknowledge to rise, lowers its request, and waits for the acknowledge to fall. Only when that last event is seen does the sender-side acknowledge change.

The bridge is clocked, and all inputs are taken as already synchronous to its clock. It keeps one stored copy of the last request level it accepted, so a sender toggle is recognised by comparing that copy with the live request level. A data bundle is registered at the moment a transfer is accepted. It is held steady on the receiver side for the whole level cycle.

A second sender toggle that arrives while a level cycle is still running is not lost. It is served as soon as the running cycle has finished.

Top module: `phase_bridge`

## Requirements
- R1: After reset, `lvlReqOut`, `togAckOut` and `dataOut` are all 0, and the stored request phase is 0.
- R2: When `togReqIn` differs from the stored phase while the bridge is idle and `lvlAckIn` is low, `lvlReqOut` is 1 after the next clock edge.
- R3: Once high, `lvlReqOut` stays high while `lvlAckIn` is low. It goes low on the first clock edge at which `lvlAckIn` is sampled high.
- R4: After `lvlReqOut` falls, it stays low for as long as `lvlAckIn` remains high.
- R5: `togAckOut` inverts exactly once per level cycle, on the edge at which `lvlAckIn` is sampled low after `lvlReqOut` has fallen. It never changes on an edge where `lvlReqOut` rises or is high.
- R6: A falling change of `togReqIn` (1 to 0) starts a transfer exactly like a rising one.
- R7: A `togReqIn` change that arrives while a level cycle is in progress is served afterwards. `lvlReqOut` rises again on the clock edge after the one at which `togAckOut` inverts.
- R8: `dataOut` loads `dataIn` on the edge where `lvlReqOut` rises. It keeps that value, whatever `dataIn` does, until the next rise.
- R9: With no pending sender change, movement of `lvlAckIn` has no effect: `lvlReqOut` stays 0, and `togAckOut` and `dataOut` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| togReqIn | input | 1 | Sender request; every change is one transfer |
| togAckOut | output | 1 | Sender acknowledge; inverts once per finished transfer |
| dataIn | input | DATA_W | Data bundle from the sender |
| lvlReqOut | output | 1 | Receiver request level |
| lvlAckIn | input | 1 | Receiver acknowledge level |
| dataOut | output | DATA_W | Data bundle held for the receiver |

## Verification
The checker watches the ordering rules on every cycle:
- the request holds until the acknowledge rises and drops right after it;
- the request does not rise again while the acknowledge is still high;
- the sender acknowledge changes only after a fully returned level cycle;
- the data stays frozen while a request is up.

Only the bench scenarios can show the rest:
- each sender change, in either direction, produces exactly one level cycle;
- a change arriving mid-cycle is queued and served next;
- acknowledge movement with nothing pending leaves every output untouched.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RAISE = 2'd1,
    ST_LOWER = 2'd2
  } bridgeState_e;

  typedef struct packed {
    logic accept;
    logic finish;
  } bridgeStrobe_t;

endpackage

// File: rtl/bridge_dp.sv
module bridge_dp #(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      togReqIn,
  input  logic [DATA_W-1:0]         dataIn,
  input  bridge_pkg::bridgeStrobe_t strobe,
  output logic                      reqPending,
  output logic                      togAckOut,
  output logic [DATA_W-1:0]         dataOut
);

  logic              seenPhase;
  logic              ackPhase;
  logic [DATA_W-1:0] dataReg;

  // a sender change is visible as a mismatch with the last accepted level
  assign reqPending = togReqIn ^ seenPhase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenPhase <= 1'b0;
      ackPhase  <= 1'b0;
      dataReg   <= '0;
    end else begin
      if (strobe.accept) begin
        seenPhase <= togReqIn;
        dataReg   <= dataIn;
      end
      if (strobe.finish) begin
        ackPhase <= ~ackPhase;
      end
    end
  end

  assign togAckOut = ackPhase;
  assign dataOut   = dataReg;

endmodule

// File: rtl/bridge_ctrl.sv
module bridge_ctrl (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqPending,
  input  logic                      lvlAckIn,
  output bridge_pkg::bridgeStrobe_t strobe,
  output logic                      lvlReqOut
);
  import bridge_pkg::*;

  bridgeState_e stateQ, stateD;

  always_comb begin
    stateD        = stateQ;
    strobe.accept = 1'b0;
    strobe.finish = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        // start only once the receiver has fully returned to zero
        if (reqPending && !lvlAckIn) begin
          stateD        = ST_RAISE;
          strobe.accept = 1'b1;
        end
      end
      ST_RAISE: begin
        if (lvlAckIn) stateD = ST_LOWER;
      end
      ST_LOWER: begin
        if (!lvlAckIn) begin
          stateD        = ST_IDLE;
          strobe.finish = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign lvlReqOut = (stateQ == ST_RAISE);

endmodule

// File: rtl/phase_bridge.sv
module phase_bridge #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              togReqIn,
  output logic              togAckOut,
  input  logic [DATA_W-1:0] dataIn,
  output logic              lvlReqOut,
  input  logic              lvlAckIn,
  output logic [DATA_W-1:0] dataOut
);

  bridge_pkg::bridgeStrobe_t strobe;
  logic                      reqPending;

  bridge_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqPending (reqPending),
    .lvlAckIn   (lvlAckIn),
    .strobe     (strobe),
    .lvlReqOut  (lvlReqOut)
  );

  bridge_dp #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .togReqIn   (togReqIn),
    .dataIn     (dataIn),
    .strobe     (strobe),
    .reqPending (reqPending),
    .togAckOut  (togAckOut),
    .dataOut    (dataOut)
  );

endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              togReqIn,
  input logic              togAckOut,
  input logic [DATA_W-1:0] dataIn,
  input logic              lvlReqOut,
  input logic              lvlAckIn,
  input logic [DATA_W-1:0] dataOut
);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lvlReqOut && !lvlAckIn) |=> lvlReqOut);

  p_req_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lvlReqOut && lvlAckIn) |=> !lvlReqOut);

  p_no_rerise_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!lvlReqOut && lvlAckIn) |=> !lvlReqOut);

  p_ack_after_rtz_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(togAckOut) |-> (!lvlReqOut && $past(!lvlReqOut) && $past(!lvlAckIn)));

  p_ack_quiet_on_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lvlReqOut) |-> $stable(togAckOut));

  p_data_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    lvlReqOut |=> $stable(dataOut));

endmodule

bind phase_bridge bridge_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_phase_bridge.sv
`timescale 1ns/1ps
module test_phase_bridge;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          togReqIn = 1'b0;
  logic          togAckOut;
  logic [DW-1:0] dataIn = '0;
  logic          lvlReqOut;
  logic          lvlAckIn = 1'b0;
  logic [DW-1:0] dataOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  phase_bridge #(.DATA_W(DW)) i_phase_bridge (
    .clk(clk), .rstN(rstN), .togReqIn(togReqIn), .togAckOut(togAckOut),
    .dataIn(dataIn), .lvlReqOut(lvlReqOut), .lvlAckIn(lvlAckIn), .dataOut(dataOut)
  );

  // behavioural reference: phase memory, a step counter and an ack toggle
  logic          mSeen = 1'b0;
  int            mStep = 0;   // 0 idle, 1 request up, 2 waiting for ack low
  logic          mAck = 1'b0;
  logic [DW-1:0] mData = '0;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mSeen = 1'b0; mStep = 0; mAck = 1'b0; mData = '0;
    end else if (mStep == 0) begin
      if (togReqIn != mSeen && !lvlAckIn) begin
        mSeen = togReqIn; mData = dataIn; mStep = 1;
      end
    end else if (mStep == 1) begin
      if (lvlAckIn) mStep = 2;
    end else begin
      if (!lvlAckIn) begin mStep = 0; mAck = ~mAck; end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN) begin
      chk("R2/R3/R4 lvlReqOut vs model", {31'd0, lvlReqOut}, {31'd0, (mStep == 1)});
      chk("R5 togAckOut vs model", {31'd0, togAckOut}, {31'd0, mAck});
      chk("R8 dataOut vs model", {24'd0, dataOut}, {24'd0, mData});
    end
  end

  always @(posedge clk) begin
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired, all R tags unfinished: actual=%0d expected<=5000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic xfer(input logic [DW-1:0] d, input int hiWait, input int loWait);
    logic prevAck;
    @(negedge clk);
    togReqIn = ~togReqIn;
    dataIn = d;
    @(negedge clk);
    chk("R2 request rises one edge after toggle", {31'd0, lvlReqOut}, 32'd1);
    chk("R8 data captured at rise", {24'd0, dataOut}, {24'd0, d});
    dataIn = ~d;
    repeat (hiWait) @(negedge clk);
    chk("R3 request held while ack low", {31'd0, lvlReqOut}, 32'd1);
    chk("R8 data held while request high", {24'd0, dataOut}, {24'd0, d});
    prevAck = togAckOut;
    lvlAckIn = 1'b1;
    @(negedge clk);
    chk("R3 request drops after ack high", {31'd0, lvlReqOut}, 32'd0);
    for (int i = 0; i < loWait; i++) begin
      @(negedge clk);
      chk("R4 request stays low while ack high", {31'd0, lvlReqOut}, 32'd0);
      chk("R5 no early ack toggle", {31'd0, togAckOut}, {31'd0, prevAck});
    end
    lvlAckIn = 1'b0;
    @(negedge clk);
    chk("R5 ack toggles after return to zero", {31'd0, togAckOut}, {31'd0, ~prevAck});
  endtask

  initial begin
    logic ackNow;
    repeat (3) @(negedge clk);
    chk("R1 reset lvlReqOut", {31'd0, lvlReqOut}, 32'd0);
    chk("R1 reset togAckOut", {31'd0, togAckOut}, 32'd0);
    chk("R1 reset dataOut", {24'd0, dataOut}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {31'd0, lvlReqOut}, 32'd0);

    xfer(8'hA5, 2, 1);   // rising toggle
    xfer(8'h3C, 0, 3);   // falling toggle
    chk("R6 falling toggle completed", {31'd0, togAckOut}, 32'd0);
    xfer(8'h7E, 4, 0);

    // ack movement with nothing pending
    ackNow = togAckOut;
    dataIn = 8'h11;
    lvlAckIn = 1'b1;
    repeat (3) @(negedge clk);
    lvlAckIn = 1'b0;
    @(negedge clk);
    chk("R9 request stays low", {31'd0, lvlReqOut}, 32'd0);
    chk("R9 ack unchanged", {31'd0, togAckOut}, {31'd0, ackNow});
    chk("R9 data unchanged", {24'd0, dataOut}, 32'h7E);

    // second toggle queued during a running cycle
    togReqIn = ~togReqIn; dataIn = 8'h42;
    @(negedge clk);
    chk("R7 first request up", {31'd0, lvlReqOut}, 32'd1);
    togReqIn = ~togReqIn; dataIn = 8'h99;
    repeat (2) @(negedge clk);
    lvlAckIn = 1'b1;
    @(negedge clk);
    ackNow = togAckOut;
    lvlAckIn = 1'b0;
    @(negedge clk);
    chk("R7 first cycle acknowledged", {31'd0, togAckOut}, {31'd0, ~ackNow});
    chk("R7 request low on ack edge", {31'd0, lvlReqOut}, 32'd0);
    @(negedge clk);
    chk("R7 queued request rises next edge", {31'd0, lvlReqOut}, 32'd1);
    chk("R7 queued data delivered", {24'd0, dataOut}, 32'h99);
    lvlAckIn = 1'b1;
    @(negedge clk);
    lvlAckIn = 1'b0;
    @(negedge clk);
    chk("R7 queued cycle acknowledged", {31'd0, togAckOut}, {31'd0, ackNow});
    repeat (3) @(negedge clk);
    chk("R7 nothing further pending", {31'd0, lvlReqOut}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule